// File: doc/BRIEF.md
# Receiver lock-mode switchover controller

This block chooses what a receiver clock-recovery loop is trained on: the local reference clock or the incoming data stream. It compares the rate of the recovered clock with the reference clock over a fixed measurement window and checks the result against one of four selectable parts-per-million tolerances. The loop moves to data tracking only when that tolerance is met and an external phase-match flag is high at the same time.

All logic runs on one clock. The reference and recovered clocks are seen only as single-cycle count pulses in that clock's domain. Two asynchronous override inputs can force the loop onto either source. When neither override is active, the switchover is automatic. The block drives a mode-select output and a status flag that is high while the loop tracks data. After two consecutive failed windows in data mode, the loop falls back to the reference.

Top module: `rx_lock_switch`

## Requirements
- R1: While `rst_n` is low at a rising edge, and after that edge, `track_data` and `data_locked` are 0 and the measurement counters restart from zero.
- R2: A window ends on the 2^WIN_LOG2-th `ref_tick`. Call N the number of cycles in the window that had `rec_tick` high. The window passes when |N − 2^WIN_LOG2| ≤ floor(2^WIN_LOG2 · P / 10^6). P is selected by `ppm_sel`: 0 gives 125, 1 gives 250, 2 gives 500 and 3 gives 1000. `ppm_sel` is sampled at the window's last tick.
- R3: In automatic mode and in reference tracking, a passing window with `phase_ok` high moves the loop to data tracking. `track_data` rises on the rising edge after the edge that sampled the window's last `ref_tick`.
- R4: In automatic mode, if `phase_ok` is low in that evaluation cycle, the loop stays in reference tracking even when the window passes.
- R5: In automatic data tracking, two consecutive failing windows return the loop to reference tracking. A single failing window leaves data tracking in place. So does a failing window that is followed by a passing one.
- R6: With `force_data` = 1, the loop tracks data (`track_data` = 1) whatever the value of `force_ref`.
- R7: With `force_ref` = 1 and `force_data` = 0, the loop tracks the reference (`track_data` = 0), and passing windows have no effect.
- R8: Each override goes through a two-flop synchronizer. An override change driven before rising edge E1 first shows at the outputs after the third rising edge counted from E1.
- R9: `data_locked` is high exactly when the loop tracks data, in both automatic and forced modes.
- R10: When both overrides return to 0, automatic operation restarts in reference tracking with a cleared failure history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, the domain of all count pulses |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One pulse per reference clock cycle |
| rec_tick | input | 1 | One pulse per recovered clock cycle |
| phase_ok | input | 1 | Synchronous phase-match qualifier |
| ppm_sel | input | 2 | Tolerance select: 0=125, 1=250, 2=500, 3=1000 PPM |
| force_data | input | 1 | Asynchronous override to data tracking (dominant) |
| force_ref | input | 1 | Asynchronous override to reference tracking |
| track_data | output | 1 | Mode select: 1 means track data, 0 means track reference |
| data_locked | output | 1 | Status: high while tracking data |

## Verification
The assertions assume that `ppm_sel` and `phase_ok` are steady around the end of a window. They also assume that WIN_LOG2 is at least 1, so two window results can never fall on adjacent cycles. The bench sets the selector and the phase flag before each window starts and holds them until the result has been sampled. It changes the overrides only between windows. To produce an exact recovered count, it gates `rec_tick` low for a few cycles, or it holds `ref_tick` low while `rec_tick` stays high. This places every deviation precisely on either side of each tolerance limit.

// File: rtl/rxl_pkg.sv
// Shared definitions for the lock-mode switchover controller.
// Holds the automatic-mode state type and the tolerance limit function.
package rxl_pkg;

    typedef enum logic {
        TRK_REF  = 1'b0,
        TRK_DATA = 1'b1
    } trk_mode_e;

    // Map the two-bit selector onto its parts-per-million value.
    function automatic longint ppm_of(input int sel);
        case (sel)
            0:       return 125;
            1:       return 250;
            2:       return 500;
            default: return 1000;
        endcase
    endfunction

    // Largest allowed count deviation for a window of 2^wl ticks.
    function automatic longint ppm_limit(input int wl, input int sel);
        return ((64'd1 << wl) * ppm_of(sel)) / 64'd1000000;
    endfunction

endpackage

// File: rtl/rxl_sync.sv
// Two-flop synchronizer for a vector of asynchronous level inputs.
// Assumes each bit is a slow level, so bits are not kept coherent with one another.
module rxl_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the asynchronous levels through two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/rxl_freq_meter.sv
// Window frequency comparator. It counts recovered pulses over 2^WIN_LOG2
// reference pulses and flags whether the absolute deviation is within the
// selected PPM limit. The result is a one-cycle win_done with a held in_tol.
// Assumes WIN_LOG2 >= 1 and that ppm_sel is steady at the window end.
module rxl_freq_meter #(
    parameter int WIN_LOG2 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       rec_tick,
    input  logic [1:0] ppm_sel,
    output logic       win_done,
    output logic       in_tol
);

    localparam int WIN = 1 << WIN_LOG2;
    localparam int RW  = WIN_LOG2 + 2;

    localparam logic [RW:0] LIM_TAB [4] = '{
        (RW+1)'(rxl_pkg::ppm_limit(WIN_LOG2, 0)),
        (RW+1)'(rxl_pkg::ppm_limit(WIN_LOG2, 1)),
        (RW+1)'(rxl_pkg::ppm_limit(WIN_LOG2, 2)),
        (RW+1)'(rxl_pkg::ppm_limit(WIN_LOG2, 3))
    };

    logic [WIN_LOG2-1:0] ref_cnt_q;
    logic [RW-1:0]       rec_cnt_q;
    logic                win_end;
    logic [RW:0]         rec_total;
    logic [RW:0]         dev_abs;
    logic [RW:0]         lim_sel;

    // The window closes on the last reference pulse.
    assign win_end   = ref_tick && (ref_cnt_q == '1);
    assign rec_total = {1'b0, rec_cnt_q} + (RW+1)'(rec_tick);

    // Find the absolute deviation and pick the active limit.
    always_comb begin
        if (rec_total >= (RW+1)'(WIN))
            dev_abs = rec_total - (RW+1)'(WIN);
        else
            dev_abs = (RW+1)'(WIN) - rec_total;
        lim_sel = LIM_TAB[ppm_sel];
    end

    // Run both counters and latch the comparison at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_cnt_q <= '0;
            rec_cnt_q <= '0;
            win_done  <= 1'b0;
            in_tol    <= 1'b0;
        end else begin
            win_done <= win_end;
            if (win_end) begin
                ref_cnt_q <= '0;
                rec_cnt_q <= '0;
                in_tol    <= (dev_abs <= lim_sel);
            end else begin
                if (ref_tick)
                    ref_cnt_q <= ref_cnt_q + 1'b1;
                if (rec_tick && (rec_cnt_q != '1))
                    rec_cnt_q <= rec_cnt_q + 1'b1;
            end
        end
    end

    AST_WIN_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done) else $error("window results too close"); // R2

endmodule

// File: rtl/rxl_mode_fsm.sv
// Lock-mode decision logic. It applies the override truth table (force_data
// dominant, then force_ref, otherwise automatic). In automatic mode it enters
// data tracking on a passing window with phase match, and it leaves after two
// consecutive failing windows. Assumes the override inputs are synchronized.
module rxl_mode_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic s_force_data,
    input  logic s_force_ref,
    input  logic win_done,
    input  logic in_tol,
    input  logic phase_ok,
    output logic track_data,
    output logic data_locked
);

    import rxl_pkg::*;

    trk_mode_e auto_q, auto_nxt;
    logic      miss_q, miss_nxt;
    logic      track_nxt;
    logic      any_force;

    assign any_force = s_force_data || s_force_ref;

    // Next automatic state; an override parks it in reference tracking.
    always_comb begin
        auto_nxt = auto_q;
        miss_nxt = miss_q;
        if (any_force) begin
            auto_nxt = TRK_REF;
            miss_nxt = 1'b0;
        end else if (win_done) begin
            case (auto_q)
                TRK_REF: begin
                    miss_nxt = 1'b0;
                    if (in_tol && phase_ok)
                        auto_nxt = TRK_DATA;
                end
                default: begin
                    if (in_tol) begin
                        miss_nxt = 1'b0;
                    end else if (miss_q) begin
                        auto_nxt = TRK_REF;
                        miss_nxt = 1'b0;
                    end else begin
                        miss_nxt = 1'b1;
                    end
                end
            endcase
        end
    end

    // Resolve the override truth table into the mode select.
    always_comb begin
        if (s_force_data)
            track_nxt = 1'b1;
        else if (s_force_ref)
            track_nxt = 1'b0;
        else
            track_nxt = (auto_nxt == TRK_DATA);
    end

    // Register the state and both outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_q      <= TRK_REF;
            miss_q      <= 1'b0;
            track_data  <= 1'b0;
            data_locked <= 1'b0;
        end else begin
            auto_q      <= auto_nxt;
            miss_q      <= miss_nxt;
            track_data  <= track_nxt;
            data_locked <= track_nxt;
        end
    end

    AST_PHASE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_force && !track_data && win_done && !phase_ok) |=> !track_data)
        else $error("switched without phase match"); // R4

    AST_SINGLE_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_force && track_data && win_done && in_tol) |=> track_data)
        else $error("left data mode on a passing window"); // R5

    AST_FORCE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        s_force_data |=> track_data) else $error("data override ignored"); // R6

    AST_FORCE_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (s_force_ref && !s_force_data) |=> !track_data)
        else $error("reference override ignored"); // R7

    AST_STATUS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        data_locked == track_data) else $error("status differs from mode"); // R9

endmodule

// File: rtl/rx_lock_switch.sv
// Top of the receiver lock-mode switchover controller. It synchronizes the
// overrides, measures the frequency per window and resolves the mode.
// Assumes the count pulses and phase_ok are already in the clk domain.
module rx_lock_switch #(
    parameter int WIN_LOG2 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       rec_tick,
    input  logic       phase_ok,
    input  logic [1:0] ppm_sel,
    input  logic       force_data,
    input  logic       force_ref,
    output logic       track_data,
    output logic       data_locked
);

    logic [1:0] force_sync;
    logic       win_done;
    logic       in_tol;

    rxl_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({force_data, force_ref}),
        .sync_o  (force_sync)
    );

    rxl_freq_meter #(.WIN_LOG2(WIN_LOG2)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .rec_tick (rec_tick),
        .ppm_sel  (ppm_sel),
        .win_done (win_done),
        .in_tol   (in_tol)
    );

    rxl_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .s_force_data (force_sync[1]),
        .s_force_ref  (force_sync[0]),
        .win_done     (win_done),
        .in_tol       (in_tol),
        .phase_ok     (phase_ok),
        .track_data   (track_data),
        .data_locked  (data_locked)
    );

endmodule

// File: tb/rx_lock_switch_tb_top.sv
module rx_lock_switch_tb_top;

    localparam int WL  = 13;
    localparam int WIN = 1 << WL;   // limits: 1, 2, 4, 8

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       rec_tick = 1'b0;
    logic       phase_ok = 1'b0;
    logic [1:0] ppm_sel = 2'd0;
    logic       force_data = 1'b0;
    logic       force_ref = 1'b0;
    logic       track_data;
    logic       data_locked;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    rx_lock_switch #(.WIN_LOG2(WL)) dut_i (
        .clk, .rst_n, .ref_tick, .rec_tick, .phase_ok, .ppm_sel,
        .force_data, .force_ref, .track_data, .data_locked
    );

    typedef struct packed {
        logic [1:0]        sel;
        logic signed [7:0] dev;
        logic              ph;
        logic              exp_lock;
    } vec_t;

    // R2 R3 R4: each row starts from reset and runs one window.
    localparam vec_t VECS [8] = '{
        '{2'd0,  8'sd1, 1'b1, 1'b1},
        '{2'd0,  8'sd2, 1'b1, 1'b0},
        '{2'd1, -8'sd2, 1'b1, 1'b1},
        '{2'd1, -8'sd3, 1'b1, 1'b0},
        '{2'd2,  8'sd4, 1'b0, 1'b0},
        '{2'd2,  8'sd5, 1'b1, 1'b0},
        '{2'd3, -8'sd8, 1'b1, 1'b1},
        '{2'd3,  8'sd9, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One window with deviation dev; returns at the sampling point after evaluation.
    task automatic run_win(input int sel, input int dev, input logic ph);
        ppm_sel  = 2'(sel);
        phase_ok = ph;
        for (int i = 0; i < dev; i++) begin
            ref_tick = 1'b0;
            rec_tick = 1'b1;
            @(negedge clk);
        end
        for (int i = 0; i < WIN; i++) begin
            ref_tick = 1'b1;
            rec_tick = (i < -dev) ? 1'b0 : 1'b1;
            @(negedge clk);
        end
        ref_tick = 1'b0;
        rec_tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        check("R1 reset track_data", track_data, 1'b0);
        check("R1 reset data_locked", data_locked, 1'b0);

        for (int v = 0; v < 8; v++) begin
            do_reset();
            run_win(int'(VECS[v].sel), int'(VECS[v].dev), VECS[v].ph);
            check($sformatf("R2 R3 R4 vector %0d mode", v), track_data, VECS[v].exp_lock);
            check($sformatf("R9 vector %0d status", v), data_locked, VECS[v].exp_lock);
        end

        // R5: two consecutive failing windows drop back to reference.
        do_reset();
        run_win(3, 0, 1'b1);
        check("R3 lock before dropout", track_data, 1'b1);
        run_win(3, 20, 1'b0);
        check("R5 single miss holds", track_data, 1'b1);
        run_win(3, -20, 1'b1);
        check("R5 second miss drops", track_data, 1'b0);
        check("R9 status after drop", data_locked, 1'b0);

        // R5: miss, pass, miss stays in data.
        do_reset();
        run_win(2, 0, 1'b1);
        run_win(2, 10, 1'b1);
        run_win(2, 3, 1'b1);
        run_win(2, -10, 1'b1);
        check("R5 interrupted misses hold", track_data, 1'b1);

        // R7 R10: reference override from data mode, then release.
        @(negedge clk);
        force_ref = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 force_ref drops data", track_data, 1'b0);
        check("R9 status forced ref", data_locked, 1'b0);
        run_win(1, 0, 1'b1);
        check("R7 passing window ignored", track_data, 1'b0);
        force_ref = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 auto restarts in reference", track_data, 1'b0);

        // R8 R6: synchronizer latency and dominance of force_data.
        force_data = 1'b1;
        force_ref  = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 not yet after two edges", track_data, 1'b0);
        @(negedge clk);
        check("R8 R6 forced data on third edge", track_data, 1'b1);
        check("R9 status forced data", data_locked, 1'b1);
        force_ref = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 force_data alone", track_data, 1'b1);
        force_data = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 release not yet", track_data, 1'b1);
        @(negedge clk);
        check("R10 release to reference", track_data, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule